// File: doc/BRIEF.md
# Per-Channel Fine Digital Gain

This block scales digitized colour samples by a programmable factor between 1.0 and just under 2.0. Each of the three channels has its own 8-bit offset-binary gain byte; the applied factor is one plus the byte divided by 256. A byte of zero passes samples through unchanged.

Every channel computes sample × (256 + byte) and scales the product back with round-to-nearest, ties rounding up. Any result above full scale clips to the largest code. Two pipeline stages give a fixed latency, and a valid strobe travels alongside the data. Each channel captures its gain byte in the same clock edge as its sample. A gain change therefore affects only samples accepted after that change and has no effect on samples already in the pipeline.

Top module: `fine_gain_top`

## Requirements
- R1: After reset, the output valid strobe is low and all three output samples are zero.
- R2: For each accepted sample s and gain byte g, the output equals floor((s*(256+g) + 128) / 256), which is round half up of s*(1+g/256).
- R3: An output value above 2^SAMPLE_W-1 (1023 with default widths) saturates to 2^SAMPLE_W-1. An output never exceeds this value.
- R4: A gain byte of 00h passes the sample through unchanged. Byte 80h gives 1.5x and byte FFh gives 511/256 x.
- R5: Each channel uses only its own gain byte. Channel 0 uses gain0, channel 1 uses gain1 and channel 2 uses gain2.
- R6: The output valid strobe equals the input valid strobe delayed by exactly two clock cycles.
- R7: Each sample is scaled with the gain byte present in the cycle in which in_valid was high. A later change to the byte does not alter results already in flight.
- R8: While out_valid is low, the output samples keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_s0 | input | SAMPLE_W | Channel 0 sample |
| in_s1 | input | SAMPLE_W | Channel 1 sample |
| in_s2 | input | SAMPLE_W | Channel 2 sample |
| gain0 | input | GAIN_W | Channel 0 gain byte |
| gain1 | input | GAIN_W | Channel 1 gain byte |
| gain2 | input | GAIN_W | Channel 2 gain byte |
| out_valid | output | 1 | Result strobe |
| out_s0 | output | SAMPLE_W | Channel 0 result |
| out_s1 | output | SAMPLE_W | Channel 1 result |
| out_s2 | output | SAMPLE_W | Channel 2 result |

## Verification
The bench targets the rounding tie, for example sample 1 with byte 80h, which must give 2. A design that truncates would give 1. The bench also drives the clip boundary, where sample 1023 with byte FFh and sample 683 with byte 80h must give 1023. A missing or misplaced clamp would wrap these results to small values.

Gain bytes change on every cycle while samples stream back to back. A design that read the byte at the output stage would then use the wrong factor on in-flight samples. Distinct bytes per channel expose any swap of the gain inputs, and idle gaps between samples expose output registers that update without a valid sample.

// File: rtl/fine_gain_pkg.sv
package fine_gain_pkg;
   localparam int NUM_CH = 3;
endpackage

// File: rtl/fine_gain_lane.sv
module fine_gain_lane #(
   parameter int SAMPLE_W = 10,
   parameter int GAIN_W   = 8,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv0,
   input  logic                adv1,
   input  logic [SAMPLE_W-1:0] samp,
   input  logic [GAIN_W-1:0]   code,
   output logic [SAMPLE_W-1:0] res
);
   localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
   localparam int SUM_W  = PROD_W + 1;
   localparam logic [SAMPLE_W-1:0] FULL = '1;

   initial begin
      assert (SAMPLE_W >= 2 && SAMPLE_W <= 24) else $error("SAMPLE_W out of range");
      assert (GAIN_W >= 2 && GAIN_W <= 16) else $error("GAIN_W out of range");
   end

   logic [PROD_W-1:0] prod_q;
   logic [SUM_W-1:0]  rnd;
   logic [SUM_W-GAIN_W-1:0] scaled;

   // stage 1: capture the product with the gain in force at acceptance
   always_ff @(posedge clk) begin
      if (!rst_n)
         prod_q <= '0;
      else if (adv0)
         prod_q <= PROD_W'(samp) * PROD_W'({1'b1, code});
   end

   generate
      if (ROUND_EN) begin : g_round
         assign rnd = SUM_W'(prod_q) + SUM_W'(1) * SUM_W'(2 ** (GAIN_W - 1));
      end else begin : g_trunc
         assign rnd = SUM_W'(prod_q);
      end
   endgenerate

   assign scaled = rnd[SUM_W-1:GAIN_W];

   // stage 2: scale back and clip
   always_ff @(posedge clk) begin
      if (!rst_n)
         res <= '0;
      else if (adv1)
         res <= (scaled > (SUM_W-GAIN_W)'(FULL)) ? FULL : scaled[SAMPLE_W-1:0];
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adv1 && (prod_q >= PROD_W'(FULL) * PROD_W'(2 ** GAIN_W)) |=> res == FULL);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !adv1 |=> $stable(res));
endmodule

// File: rtl/fine_gain_valid_pipe.sv
module fine_gain_valid_pipe #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vin,
   output logic [DEPTH-1:0] stage
);
   initial assert (DEPTH >= 1) else $error("DEPTH must be positive");

   always_ff @(posedge clk) begin
      if (!rst_n)
         stage <= '0;
      else
         stage <= DEPTH'({stage, vin});
   end

   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vin |=> stage[0]);
endmodule

// File: rtl/fine_gain_top.sv
module fine_gain_top
   import fine_gain_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int GAIN_W   = 8,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_s0,
   input  logic [SAMPLE_W-1:0] in_s1,
   input  logic [SAMPLE_W-1:0] in_s2,
   input  logic [GAIN_W-1:0]   gain0,
   input  logic [GAIN_W-1:0]   gain1,
   input  logic [GAIN_W-1:0]   gain2,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_s0,
   output logic [SAMPLE_W-1:0] out_s1,
   output logic [SAMPLE_W-1:0] out_s2
);
   localparam int LAT = 2;

   logic [LAT-1:0] vstage;
   logic [SAMPLE_W-1:0] s_arr [NUM_CH];
   logic [GAIN_W-1:0]   g_arr [NUM_CH];
   logic [SAMPLE_W-1:0] r_arr [NUM_CH];

   assign s_arr[0] = in_s0; assign s_arr[1] = in_s1; assign s_arr[2] = in_s2;
   assign g_arr[0] = gain0; assign g_arr[1] = gain1; assign g_arr[2] = gain2;

   fine_gain_valid_pipe #(.DEPTH(LAT)) u_vp (
      .clk(clk), .rst_n(rst_n), .vin(in_valid), .stage(vstage));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         fine_gain_lane #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .ROUND_EN(ROUND_EN)) u_lane (
            .clk(clk), .rst_n(rst_n), .adv0(in_valid), .adv1(vstage[0]),
            .samp(s_arr[c]), .code(g_arr[c]), .res(r_arr[c]));
         // R4: zero gain is identity, two cycles on
         assert_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && g_arr[c] == '0 |=> ##1 r_arr[c] == $past(s_arr[c], 2));
      end
   endgenerate

   assign out_valid = vstage[LAT-1];
   assign out_s0 = r_arr[0];
   assign out_s1 = r_arr[1];
   assign out_s2 = r_arr[2];

   assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);
   assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/sim_fine_gain_top.sv
module sim_fine_gain_top;
   logic clk = 0, rst_n = 0, in_valid = 0;
   logic [9:0] s0 = 0, s1 = 0, s2 = 0;
   logic [7:0] g0 = 0, g1 = 0, g2 = 0;
   logic ov;
   logic [9:0] o0, o1, o2;
   int checks = 0, errors = 0;
   logic [29:0] expq [$];
   bit done = 0;

   always #5 clk = ~clk;

   fine_gain_top u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_s0(s0), .in_s1(s1), .in_s2(s2), .gain0(g0), .gain1(g1), .gain2(g2),
      .out_valid(ov), .out_s0(o0), .out_s1(o1), .out_s2(o2));

   function automatic logic [9:0] ref_gain(input int s, input int g);
      int r;
      r = (s * (256 + g) + 128) / 256;
      return (r > 1023) ? 10'd1023 : 10'(r);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input int a, input int b, input int c,
                        input int ga, input int gb, input int gc);
      @(negedge clk);
      in_valid = 1; s0 = 10'(a); s1 = 10'(b); s2 = 10'(c);
      g0 = 8'(ga); g1 = 8'(gb); g2 = 8'(gc);
      expq.push_back({ref_gain(a, ga), ref_gain(b, gb), ref_gain(c, gc)});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0;
         g0 = 8'(g0 + 37); g1 = 8'(g1 + 91); g2 = 8'(g2 + 13); // R7 gain churn
      end
   endtask

   // monitor: valid two cycles after drive (R6); values per R2/R3/R5
   logic [9:0] last0, last1, last2;
   logic [1:0] vin_d;
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6", ov, vin_d[1]);
         if (ov) begin
            logic [29:0] e;
            if (expq.size() == 0) chk("R6 unexpected", 1, 0);
            else begin
               e = expq.pop_front();
               chk("R2/R5 ch0", o0, e[29:20]);
               chk("R2/R5 ch1", o1, e[19:10]);
               chk("R2/R5 ch2", o2, e[9:0]);
            end
         end else begin
            chk("R8 hold", {o0, o1, o2}, {last0, last1, last2});
         end
         last0 = o0; last1 = o1; last2 = o2;
      end
   end
   always @(posedge clk) vin_d <= rst_n ? {vin_d[0], in_valid} : 2'b00;

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      vin_d = 0;
      repeat (3) @(negedge clk);
      chk("R1 valid", ov, 0);
      chk("R1 data", {o0, o1, o2}, 0);
      rst_n = 1;
      last0 = 0; last1 = 0; last2 = 0;
      drive(100, 200, 300, 0, 0, 0);          // R4 unity
      drive(100, 1, 1023, 8'h80, 8'h80, 8'hFF); // R4 1.5 / R2 tie / R3 clip
      drive(683, 682, 511, 8'h80, 8'h80, 8'hFF); // R3 boundary
      drive(5, 5, 5, 1, 8'h40, 8'hC0);        // R5 distinct gains
      drive(3, 1, 513, 8'h2B, 8'h7F, 8'hFF);  // R7 back to back changes
      idle(3);
      drive(1023, 0, 512, 0, 8'hFF, 8'hFF);   // R4 / R3
      idle(1);
      for (int i = 0; i < 200; i++) begin
         drive((i * 97) % 1024, (i * 311 + 5) % 1024, (i * 7) % 1024,
               (i * 53) % 256, (i * 29 + 128) % 256, 255 - i % 256);
         if (i % 7 == 3) idle(2);
      end
      idle(4);
      chk("R6 drained", expq.size(), 0);
      chk("R2 tie spot", ref_gain(1, 128), 2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule